// File: doc/BRIEF.md
# Playback DMA Byte Counter and Interrupt Engine

This block sits between the playback format register and the DMA channel of an audio codec. A write to the format byte is decoded into a sample rate in hertz, a mono or stereo flag, a sample-format code, and a byte shift. The byte shift turns a sample count into a byte count. If the byte holds a rate hole or a format code that the block cannot play, the write raises a sticky error. The settings that were in force before that write are kept.

While playback is enabled and the format is valid, the block holds the DMA request asserted and counts the bytes that the DMA side reports one at a time. With the interrupt enabled, the 16-bit base count, scaled by the byte shift, sets the byte target. The block reports the bytes left so that the DMA side can size its bursts. On the byte that completes the target it emits a one-cycle interrupt pulse and starts counting again from zero.

Top module: `play_dma_engine`

## Requirements
- R1: After reset the outputs are: rate 8000, mono, sample-format code 0, shift 0, DMA hold low, error low, interrupt low. With the interrupt disabled, `remain_o` reads all ones.
- R2: A format write updates `rate_hz_o` one clock later. Bit 0 picks one of two tables and bits 3:1 index into it. With bit 0 clear, the rates are 8000, 16000, 27420, 32000, invalid, invalid, 48000, 9000. With bit 0 set, they are 5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620.
- R3: Bit 4 of the format byte selects stereo. The sample-format code is bits 7:5 when `ext_mode_i` is high and bits 6:5 when it is low; bit 7 is then ignored. Valid codes are 0 unsigned 8-bit, 1 mu-law, 2 signed 16-bit little-endian, 3 A-law, and 6 signed 16-bit big-endian.
- R4: `shift_o` is (stereo ? 1 : 0) for codes 0, 1 and 3, and (stereo ? 2 : 1) for codes 2 and 6. A base count of 0xFFFF shifted by 2 still fits the 18-bit byte counter.
- R5: A format write with an invalid rate, or with code 4, 5 or 7, sets `fmt_err_o` one clock later and leaves the rate, channel, format and shift outputs unchanged. The error stays set until the next valid format write clears it.
- R6: A rejected format write drops `dreq_hold_o` one clock later.
- R7: A rise of `play_en_i` with no pending error, or a valid format write while enabled and not holding, raises `dreq_hold_o` one clock later and clears the byte count. Clearing `play_en_i` drops the hold one clock later.
- R8: With the interrupt enabled, `remain_o` = (base << shift) − count, and 0 when the count is at or past the target. A byte strobe is ignored, and the count stays frozen, when `remain_o` is 0 or the hold is low.
- R9: The byte that makes the count reach the target produces a one-cycle `play_irq_o` pulse in the next cycle, and the count restarts at 0.
- R10: With the interrupt disabled, bytes are still counted, `play_irq_o` stays low, and `remain_o` reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_wr_i | input | 1 | Format byte write strobe |
| fmt_byte_i | input | 8 | Format byte: rate table, rate index, stereo, format code |
| ext_mode_i | input | 1 | Enables the 3-bit format code |
| play_en_i | input | 1 | Playback enable |
| irq_en_i | input | 1 | Playback count interrupt enable |
| base_cnt_i | input | 16 | Base count in samples |
| xfer_i | input | 1 | One byte moved by DMA this cycle |
| rate_hz_o | output | 16 | Decoded sample rate in Hz |
| stereo_o | output | 1 | Stereo selected |
| sfmt_o | output | 3 | Sample-format code |
| shift_o | output | 2 | Samples-to-bytes shift |
| dreq_hold_o | output | 1 | DMA request held |
| fmt_err_o | output | 1 | Sticky format error |
| remain_o | output | 18 | Bytes left before the interrupt |
| play_irq_o | output | 1 | Interrupt set pulse |

## Verification
Format decode results and the error flag come from registers, so they are due one clock after the write strobe. The bench drives each write at a falling edge and compares at the next falling edge. The hold follows its enable, error or format-write cause by one clock and is checked the same way. `remain_o` is combinational on the count register and the base, shift and enable inputs: it is read at the falling edge after a strobe or an input change. The interrupt pulse is registered from the final byte, so it is sampled at the falling edge that ends that byte strobe and checked low again one cycle later.

// File: rtl/pde_pkg.sv
package pde_pkg;

  typedef enum logic [2:0] {
    SF_U8    = 3'd0,
    SF_ULAW  = 3'd1,
    SF_S16LE = 3'd2,
    SF_ALAW  = 3'd3,
    SF_RSV4  = 3'd4,
    SF_ADPCM = 3'd5,
    SF_S16BE = 3'd6,
    SF_RSV7  = 3'd7
  } sfmt_e;

  // 0 marks an unusable rate slot
  function automatic logic [15:0] rate_lookup(input logic tbl, input logic [2:0] idx);
    logic [15:0] hz;
    if (!tbl) begin
      case (idx)
        3'd0: hz = 16'd8000;
        3'd1: hz = 16'd16000;
        3'd2: hz = 16'd27420;
        3'd3: hz = 16'd32000;
        3'd6: hz = 16'd48000;
        3'd7: hz = 16'd9000;
        default: hz = 16'd0;
      endcase
    end else begin
      case (idx)
        3'd0: hz = 16'd5510;
        3'd1: hz = 16'd11025;
        3'd2: hz = 16'd18900;
        3'd3: hz = 16'd22050;
        3'd4: hz = 16'd37800;
        3'd5: hz = 16'd44100;
        3'd6: hz = 16'd33075;
        default: hz = 16'd6620;
      endcase
    end
    return hz;
  endfunction

  function automatic logic code_ok(input sfmt_e f);
    return (f == SF_U8) || (f == SF_ULAW) || (f == SF_S16LE) ||
           (f == SF_ALAW) || (f == SF_S16BE);
  endfunction

  function automatic logic [1:0] byte_shift(input sfmt_e f, input logic st);
    logic wide;
    wide = (f == SF_S16LE) || (f == SF_S16BE);
    return wide ? (st ? 2'd2 : 2'd1) : (st ? 2'd1 : 2'd0);
  endfunction

endpackage

// File: rtl/pde_fmt_reg.sv
module pde_fmt_reg
  import pde_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        byte_i,
  input  logic              ext_mode_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              stereo_o,
  output logic [2:0]        sfmt_o,
  output logic [1:0]        shift_o,
  output logic              err_o,
  output logic              ok_o
);

  sfmt_e       code;
  logic [15:0] hz;

  always_comb begin
    code = sfmt_e'(ext_mode_i ? byte_i[7:5] : {1'b0, byte_i[6:5]});
    hz   = rate_lookup(byte_i[0], byte_i[3:1]);
    ok_o = (hz != 16'd0) && code_ok(code);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o   <= RATE_W'(8000);
      stereo_o <= 1'b0;
      sfmt_o   <= 3'd0;
      shift_o  <= 2'd0;
      err_o    <= 1'b0;
    end else if (wr_i) begin
      err_o <= !ok_o;
      if (ok_o) begin
        rate_o   <= RATE_W'(hz);
        stereo_o <= byte_i[4];
        sfmt_o   <= code;
        shift_o  <= byte_shift(code, byte_i[4]);
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(err_o)); // R5
  AST_BAD_KEEPS_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ok_o) |=> ($stable(rate_o) && $stable(sfmt_o) && $stable(shift_o))); // R5
  AST_CODE_PLAYABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfmt_o != 3'd4) && (sfmt_o != 3'd5) && (sfmt_o != 3'd7)); // R3

endmodule

// File: rtl/pde_dreq_ctl.sv
module pde_dreq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic play_en_i,
  input  logic fmt_wr_i,
  input  logic fmt_ok_i,
  input  logic err_i,
  output logic hold_o,
  output logic start_o
);

  logic stop;

  always_comb begin
    start_o = play_en_i && !hold_o && (fmt_wr_i ? fmt_ok_i : !err_i);
    stop    = !play_en_i || (fmt_wr_i && !fmt_ok_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_o <= 1'b0;
    else if (stop)    hold_o <= 1'b0;
    else if (start_o) hold_o <= 1'b1;
  end

  AST_ERR_DROPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_wr_i && !fmt_ok_i) |=> !hold_o); // R6
  AST_EN_LOW_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_en_i |=> !hold_o); // R7

endmodule

// File: rtl/pde_byte_cnt.sv
module pde_byte_cnt #(
  parameter int CNT_W = 16,
  localparam int XFER_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              start_i,
  input  logic              xfer_i,
  input  logic              irq_en_i,
  input  logic [CNT_W-1:0]  base_i,
  input  logic [1:0]        shift_i,
  output logic [XFER_W-1:0] remain_o,
  output logic              irq_o
);

  logic [XFER_W-1:0] cnt_q, target;
  logic              accept, hit;

  always_comb begin
    target = XFER_W'(base_i) << shift_i;
    if (!irq_en_i)            remain_o = '1;
    else if (cnt_q >= target) remain_o = '0;
    else                      remain_o = target - cnt_q;
    accept = hold_i && xfer_i && (remain_o != '0);
    hit    = accept && irq_en_i && (remain_o == XFER_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= hit;
      if (start_i || hit) cnt_q <= '0;
      else if (accept)    cnt_q <= cnt_q + XFER_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && remain_o == '0 && !start_i) |=> $stable(cnt_q)); // R8
  AST_FROZEN_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !start_i) |=> $stable(cnt_q)); // R8
  AST_IRQ_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cnt_q == '0)); // R9
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o); // R10

endmodule

// File: rtl/play_dma_engine.sv
module play_dma_engine #(
  parameter int CNT_W  = 16,
  parameter int RATE_W = 16,
  localparam int XFER_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_wr_i,
  input  logic [7:0]        fmt_byte_i,
  input  logic              ext_mode_i,
  input  logic              play_en_i,
  input  logic              irq_en_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic              xfer_i,
  output logic [RATE_W-1:0] rate_hz_o,
  output logic              stereo_o,
  output logic [2:0]        sfmt_o,
  output logic [1:0]        shift_o,
  output logic              dreq_hold_o,
  output logic              fmt_err_o,
  output logic [XFER_W-1:0] remain_o,
  output logic              play_irq_o
);

  logic fmt_ok, start;

  pde_fmt_reg #(.RATE_W(RATE_W)) i_fmt (
    .clk_i, .rst_ni,
    .wr_i(fmt_wr_i), .byte_i(fmt_byte_i), .ext_mode_i,
    .rate_o(rate_hz_o), .stereo_o, .sfmt_o, .shift_o,
    .err_o(fmt_err_o), .ok_o(fmt_ok)
  );

  pde_dreq_ctl i_dreq (
    .clk_i, .rst_ni, .play_en_i,
    .fmt_wr_i, .fmt_ok_i(fmt_ok), .err_i(fmt_err_o),
    .hold_o(dreq_hold_o), .start_o(start)
  );

  pde_byte_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .hold_i(dreq_hold_o), .start_i(start), .xfer_i, .irq_en_i,
    .base_i(base_cnt_i), .shift_i(shift_o),
    .remain_o, .irq_o(play_irq_o)
  );

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dreq_hold_o) |-> (irq_en_i ? (remain_o == ((XFER_W'(base_cnt_i) << shift_o))) : 1'b1)
    || $changed(base_cnt_i) || $changed(shift_o)); // R7

endmodule

// File: tb/test_play_dma_engine.sv
module test_play_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_wr = 1'b0, ext = 1'b0, play_en = 1'b0, irq_en = 1'b0, xfer = 1'b0;
  logic [7:0]  fbyte = 8'h00;
  logic [15:0] base = 16'd0;
  logic [15:0] rate;
  logic        stereo, hold, err, irq;
  logic [2:0]  sfmt;
  logic [1:0]  shift;
  logic [17:0] remain;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  play_dma_engine i_play_dma_engine (
    .clk_i(clk), .rst_ni(rst_n), .fmt_wr_i(fmt_wr), .fmt_byte_i(fbyte),
    .ext_mode_i(ext), .play_en_i(play_en), .irq_en_i(irq_en),
    .base_cnt_i(base), .xfer_i(xfer), .rate_hz_o(rate), .stereo_o(stereo),
    .sfmt_o(sfmt), .shift_o(shift), .dreq_hold_o(hold), .fmt_err_o(err),
    .remain_o(remain), .play_irq_o(irq)
  );

  // {ext, byte, rate, stereo, code, shift, err}
  localparam logic [31:0] VEC [14] = '{
    {1'b0, 8'h00, 16'd8000,  1'b0, 3'd0, 2'd0, 1'b0},
    {1'b0, 8'h0B, 16'd44100, 1'b0, 3'd0, 2'd0, 1'b0},
    {1'b0, 8'h5D, 16'd33075, 1'b1, 3'd2, 2'd2, 1'b0},
    {1'b0, 8'hC1, 16'd5510,  1'b0, 3'd2, 2'd1, 1'b0},
    {1'b1, 8'hC1, 16'd5510,  1'b0, 3'd6, 2'd1, 1'b0},
    {1'b0, 8'h38, 16'd0,     1'b0, 3'd0, 2'd0, 1'b1},
    {1'b1, 8'h3C, 16'd48000, 1'b1, 3'd1, 2'd1, 1'b0},
    {1'b1, 8'h80, 16'd0,     1'b0, 3'd0, 2'd0, 1'b1},
    {1'b1, 8'hA2, 16'd0,     1'b0, 3'd0, 2'd0, 1'b1},
    {1'b1, 8'h7E, 16'd9000,  1'b1, 3'd3, 2'd1, 1'b0},
    {1'b1, 8'hE0, 16'd0,     1'b0, 3'd0, 2'd0, 1'b1},
    {1'b0, 8'h6F, 16'd6620,  1'b0, 3'd3, 2'd0, 1'b0},
    {1'b1, 8'h3A, 16'd0,     1'b0, 3'd0, 2'd0, 1'b1},
    {1'b1, 8'hD7, 16'd22050, 1'b1, 3'd6, 2'd2, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_fmt(input logic e, input logic [7:0] b);
    @(negedge clk); fmt_wr = 1'b1; ext = e; fbyte = b;
    @(negedge clk); fmt_wr = 1'b0;
  endtask

  task automatic pulse(output logic got);
    @(negedge clk); xfer = 1'b1;
    @(negedge clk); xfer = 1'b0; got = irq;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] g_rate;
    logic        g_st, g;
    logic [2:0]  g_code;
    logic [1:0]  g_sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rate", rate, 8000); chk("R1 stereo", stereo, 0);
    chk("R1 sfmt", sfmt, 0);    chk("R1 shift", shift, 0);
    chk("R1 hold", hold, 0);    chk("R1 err", err, 0);
    chk("R1 irq", irq, 0);      chk("R1 remain", remain, 18'h3FFFF);

    g_rate = 16'd8000; g_st = 1'b0; g_code = 3'd0; g_sh = 2'd0;
    for (int i = 0; i < 14; i++) begin
      wr_fmt(VEC[i][31], VEC[i][30:23]);
      chk("R5 err", err, VEC[i][0]);
      if (!VEC[i][0]) begin
        g_rate = VEC[i][22:7]; g_st = VEC[i][6]; g_code = VEC[i][5:3]; g_sh = VEC[i][2:1];
      end
      chk("R2 rate", rate, g_rate);
      chk("R3 stereo", stereo, g_st);
      chk("R3 sfmt", sfmt, g_code);
      chk("R4 shift", shift, g_sh);
      chk("R7 hold idle", hold, 0);
    end

    // counting: 8000 stereo u8, shift 1, base 3 -> 6 bytes
    wr_fmt(1'b0, 8'h10);
    chk("R4 shift stereo u8", shift, 1);
    @(negedge clk); base = 16'd3; irq_en = 1'b1;
    @(negedge clk); chk("R8 remain", remain, 6);
    play_en = 1'b1;
    @(negedge clk); chk("R7 hold rise", hold, 1);
    for (int k = 0; k < 5; k++) begin
      pulse(g);
      chk("R9 no early irq", g, 0);
    end
    chk("R8 remain 1", remain, 1);
    pulse(g);
    chk("R9 irq", g, 1);
    chk("R9 restart", remain, 6);
    @(negedge clk); chk("R9 one cycle", irq, 0);

    // R8 zero target blocks bytes
    base = 16'd0;
    @(negedge clk); chk("R8 zero remain", remain, 0);
    pulse(g); chk("R8 no irq blocked", g, 0);
    base = 16'd3;
    @(negedge clk); chk("R8 blocked byte ignored", remain, 6);

    // R8 frozen without hold, R7 release and restart
    pulse(g); pulse(g);
    chk("R8 two bytes", remain, 4);
    play_en = 1'b0;
    @(negedge clk); chk("R7 hold drop", hold, 0);
    pulse(g); pulse(g); pulse(g);
    chk("R8 no hold frozen", remain, 4);
    play_en = 1'b1;
    @(negedge clk); chk("R7 re-rise", hold, 1); chk("R7 count cleared", remain, 6);

    // R6 error releases hold, valid write restarts
    pulse(g);
    wr_fmt(1'b0, 8'h38);
    chk("R6 hold released", hold, 0); chk("R5 err set", err, 1);
    wr_fmt(1'b0, 8'h10);
    chk("R5 err cleared", err, 0); chk("R7 restart", hold, 1);
    chk("R7 restart count", remain, 6);

    // R4 largest byte target
    wr_fmt(1'b1, 8'hD7);
    chk("R4 shift 2", shift, 2);
    base = 16'hFFFF;
    @(negedge clk); chk("R4 max target", remain, 18'h3FFFC);

    // R10 counting with interrupt disabled
    irq_en = 1'b0;
    @(negedge clk); chk("R10 remain ones", remain, 18'h3FFFF);
    for (int k = 0; k < 4; k++) begin
      pulse(g);
      chk("R10 no irq", g, 0);
    end
    irq_en = 1'b1; base = 16'd1;
    @(negedge clk); chk("R10 counted", remain, 0);
    base = 16'd2;
    @(negedge clk); chk("R10 counted 4", remain, 4);

    finish_run();
  end

endmodule